// File: doc/BRIEF.md
# Reset Configuration Fetch Sequencer

This block brings a microcontroller out of reset. While the active-low reset input is low it holds the external bus strobes, the address, the applied bus mode, both configuration registers, the boot flag and the clock output at fixed values. Once reset is released, the block passes it through a two-flop synchronizer. It then runs two 8-bit external reads to fetch the configuration bytes, applies the bus settings that the first byte selects, and issues the first instruction fetch.

The bus interface is a plain multiplexed read. A one-cycle address-latch strobe is followed by a read strobe that lasts a parameterized number of clocks. The data input is sampled at the edge that ends the read strobe. A separate flag marks the upper address byte as weakly driven during the configuration reads. The latched configuration bytes and the applied bus mode are outputs for the rest of the chip. An external clock output is kept in phase with an internal phase-1 signal, and it is realigned at once if the reset release leaves it out of step.

Top module: `rcfg_boot_seq`

## Requirements
- R1: While `rst_n` is low, `bus_ale`=0, `bus_rd_n`=1, `bus_addr`=0, `bus_hi_weak`=0, `bus_wide`=0, `bus_ready_en`=0, `bus_timing`=0, `cfg0`=`cfg1`=0, `boot_done`=0 and `clk_out`=1.
- R2: The reset input passes through a two-flop synchronizer. `bus_ale` is still low after the second rising clock edge that follows the release of `rst_n`, and it is high after the third.
- R3: After reset the bus performs exactly three reads, in this order: address 0x2018 (first configuration byte), 0x201A (second byte), then 0x2080 (first instruction).
- R4: Each read holds `bus_ale` high for one clock. `bus_rd_n` is then low for exactly RD_WAIT clocks (default 3), and `bus_din` is sampled only at the clock edge that ends the last of those clocks.
- R5: Both configuration reads run in 8-bit mode (`bus_wide`=0). Only `bus_din[7:0]` is stored, and the upper data byte is ignored.
- R6: The first configuration byte is decoded as follows: bit 1 = 16-bit bus, bits 3:2 = timing mode, bit 4 = ready control. `bus_wide`, `bus_timing` and `bus_ready_en` keep their reset values through both configuration reads. They show the decoded values by the address strobe of the instruction fetch.
- R7: `bus_hi_weak` is high during both configuration reads and low during the instruction fetch and afterwards.
- R8: `clk_out` toggles every clock in step with `phase1`. It equals `phase1` from the third clock edge after reset release onward, even when it is out of phase at release.
- R9: `boot_done` rises in the same cycle as the instruction-fetch address strobe and stays high until the next reset.
- R10: A reset asserted in the middle of the sequence clears the configuration registers and the bus strobes at once, without waiting for a clock edge. A complete new sequence runs after the next release.
- R11: `cfg0` and `cfg1` present the bytes read from 0x2018 and 0x201A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_din | input | 16 | Read data from the external bus |
| bus_addr | output | 16 | Address of the current read |
| bus_ale | output | 1 | Address-latch strobe, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_hi_weak | output | 1 | Upper address byte weakly driven |
| bus_wide | output | 1 | Applied bus width, 1 = 16-bit |
| bus_ready_en | output | 1 | Applied ready control |
| bus_timing | output | 2 | Applied bus timing mode |
| cfg0 | output | 8 | First configuration register |
| cfg1 | output | 8 | Second configuration register |
| boot_done | output | 1 | First instruction fetch issued |
| clk_out | output | 1 | External clock output |
| phase1 | output | 1 | Internal phase-1 signal |

## Verification
The boot sequence is tried with two first configuration bytes. One selects a 16-bit bus with ready control and timing mode 3. The other keeps an 8-bit bus and selects timing mode 1, so a wrong bit position in the decode shows up as a wrong applied mode at the fetch. The bus model returns junk in the upper data byte, and junk on every read-strobe clock except the last one. This separates correct byte masking and correct sample timing from early or full-width capture. A reset dropped during the second configuration read, followed by a boot with different bytes, shows whether the partly loaded state is cleared and the sequence restarts cleanly.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;

  typedef enum logic [2:0] {
    SQ_C0_GO, SQ_C0_WAIT, SQ_C1_GO, SQ_C1_WAIT,
    SQ_APPLY, SQ_F_GO, SQ_F_WAIT, SQ_IDLE
  } seq_st_t;

  typedef enum logic [1:0] {
    BR_IDLE, BR_ALE, BR_RD
  } rd_st_t;

  typedef struct packed {
    logic       wide;
    logic       rdy;
    logic [1:0] tim;
  } bus_mode_t;

  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned CF_WIDE    = 1;
  localparam int unsigned CF_TIM_LSB = 2;
  localparam int unsigned CF_RDY     = 4;

endpackage

// File: rtl/rcfg_rst_sync.sv
module rcfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_o = s2_q;
endmodule

// File: rtl/rcfg_phase_align.sv
module rcfg_phase_align (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_sync,
  output logic clk_out_o,
  output logic ph1_o
);
  logic ph1_q;
  logic ck_q, ck_d;

  // internal phase runs from the raw release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph1_q <= 1'b0;
    else        ph1_q <= ~ph1_q;
  end

  // output clock: toggle, or snap to the phase the internal clock takes next
  always_comb begin
    if (ck_q != ph1_q) ck_d = ~ph1_q;
    else               ck_d = ~ck_q;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) ck_q <= 1'b1;
    else           ck_q <= ck_d;
  end

  assign clk_out_o = ck_q;
  assign ph1_o     = ph1_q;

  AST_CLKOUT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_sync)
    $past(rst_sync) |-> (clk_out_o == ph1_o)); // R8
  AST_CLKOUT_TOGGLES: assert property (@(posedge clk) disable iff (!rst_sync)
    $past(rst_sync) |=> (clk_out_o != $past(clk_out_o))); // R8
endmodule

// File: rtl/rcfg_bus_read.sv
module rcfg_bus_read
  import rcfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned RD_WAIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned CNT_W = (RD_WAIT < 2) ? 1 : $clog2(RD_WAIT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RD_WAIT - 1);

  rd_st_t            st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              wide_q, wide_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    wide_d = wide_q;
    unique case (st_q)
      BR_IDLE: if (start_i) begin
        st_d   = BR_ALE;
        addr_d = addr_i;
        wide_d = wide_i;
      end
      BR_ALE: begin
        st_d  = BR_RD;
        cnt_d = '0;
      end
      BR_RD: begin
        if (cnt_q == CNT_LAST) st_d  = BR_IDLE;
        else                   cnt_d = cnt_q + 1'b1;
      end
      default: st_d = BR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BR_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      wide_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      wide_q <= wide_d;
    end
  end

  assign ale_o  = (st_q == BR_ALE);
  assign rd_n_o = (st_q != BR_RD);
  assign addr_o = addr_q;
  assign done_o = (st_q == BR_RD) && (cnt_q == CNT_LAST);

  generate
    if (DATA_W > BYTE_W) begin : g_mask
      assign data_o = wide_q ? din_i : {{(DATA_W-BYTE_W){1'b0}}, din_i[BYTE_W-1:0]};
    end else begin : g_narrow
      assign data_o = din_i;
    end
  endgenerate

  AST_ALE_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> !ale_o); // R4
  AST_RD_FOLLOWS:  assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> !rd_n_o); // R4
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_o && !$past(rd_n_o)) |-> $stable(addr_o)); // R3
endmodule

// File: rtl/rcfg_boot_seq.sv
module rcfg_boot_seq
  import rcfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned RD_WAIT = 3,
  parameter logic [ADDR_W-1:0] CFG0_ADDR  = 16'h2018,
  parameter logic [ADDR_W-1:0] CFG1_ADDR  = 16'h201A,
  parameter logic [ADDR_W-1:0] FETCH_ADDR = 16'h2080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_ale,
  output logic              bus_rd_n,
  output logic              bus_hi_weak,
  output logic              bus_wide,
  output logic              bus_ready_en,
  output logic [1:0]        bus_timing,
  output logic [7:0]        cfg0,
  output logic [7:0]        cfg1,
  output logic              boot_done,
  output logic              clk_out,
  output logic              phase1
);
  logic              rst_sync;
  seq_st_t           st_q, st_d;
  logic [7:0]        cfg0_q, cfg0_d, cfg1_q, cfg1_d;
  bus_mode_t         mode_q, mode_d;
  logic              boot_q, boot_d;
  logic              rd_start, rd_wide, rd_done;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              ccb_phase;

  rcfg_rst_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_o (rst_sync)
  );

  rcfg_phase_align u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync  (rst_sync),
    .clk_out_o (clk_out),
    .ph1_o     (phase1)
  );

  rcfg_bus_read #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RD_WAIT (RD_WAIT)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_sync),
    .start_i (rd_start),
    .addr_i  (rd_addr),
    .wide_i  (rd_wide),
    .din_i   (bus_din),
    .ale_o   (bus_ale),
    .rd_n_o  (bus_rd_n),
    .addr_o  (bus_addr),
    .done_o  (rd_done),
    .data_o  (rd_data)
  );

  // sequencer next state
  always_comb begin
    st_d     = st_q;
    cfg0_d   = cfg0_q;
    cfg1_d   = cfg1_q;
    mode_d   = mode_q;
    boot_d   = boot_q;
    rd_start = 1'b0;
    rd_addr  = CFG0_ADDR;
    rd_wide  = 1'b0;
    unique case (st_q)
      SQ_C0_GO: begin
        rd_start = 1'b1;
        st_d     = SQ_C0_WAIT;
      end
      SQ_C0_WAIT: if (rd_done) begin
        cfg0_d = rd_data[7:0];
        st_d   = SQ_C1_GO;
      end
      SQ_C1_GO: begin
        rd_start = 1'b1;
        rd_addr  = CFG1_ADDR;
        st_d     = SQ_C1_WAIT;
      end
      SQ_C1_WAIT: if (rd_done) begin
        cfg1_d = rd_data[7:0];
        st_d   = SQ_APPLY;
      end
      SQ_APPLY: begin
        mode_d.wide = cfg0_q[CF_WIDE];
        mode_d.rdy  = cfg0_q[CF_RDY];
        mode_d.tim  = cfg0_q[CF_TIM_LSB +: 2];
        st_d        = SQ_F_GO;
      end
      SQ_F_GO: begin
        rd_start = 1'b1;
        rd_addr  = FETCH_ADDR;
        rd_wide  = mode_q.wide;
        boot_d   = 1'b1;
        st_d     = SQ_F_WAIT;
      end
      SQ_F_WAIT: if (rd_done) st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      st_q   <= SQ_C0_GO;
      cfg0_q <= '0;
      cfg1_q <= '0;
      mode_q <= '0;
      boot_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cfg0_q <= cfg0_d;
      cfg1_q <= cfg1_d;
      mode_q <= mode_d;
      boot_q <= boot_d;
    end
  end

  assign ccb_phase    = (st_q == SQ_C0_GO) || (st_q == SQ_C0_WAIT) ||
                        (st_q == SQ_C1_GO) || (st_q == SQ_C1_WAIT);
  assign bus_hi_weak  = rst_sync && ccb_phase;
  assign bus_wide     = mode_q.wide;
  assign bus_ready_en = mode_q.rdy;
  assign bus_timing   = mode_q.tim;
  assign cfg0         = cfg0_q;
  assign cfg1         = cfg1_q;
  assign boot_done    = boot_q;

  AST_CCB_NARROW:   assert property (@(posedge clk) disable iff (!rst_sync)
    (bus_ale && bus_hi_weak) |-> !bus_wide); // R5
  AST_MODE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_sync)
    bus_hi_weak |-> (!bus_ready_en && bus_timing == 2'b00 && !bus_wide)); // R6
  AST_FETCH_STRONG: assert property (@(posedge clk) disable iff (!rst_sync)
    (bus_ale && boot_done) |-> !bus_hi_weak); // R7
  AST_BOOT_AT_ALE:  assert property (@(posedge clk) disable iff (!rst_sync)
    $rose(boot_done) |-> (bus_ale && bus_addr == FETCH_ADDR)); // R9
  AST_BOOT_STICKY:  assert property (@(posedge clk) disable iff (!rst_sync)
    boot_done |=> boot_done); // R9
endmodule

// File: tb/tb_rcfg_boot_seq.sv
`timescale 1ns/1ps
module tb_rcfg_boot_seq;
  localparam int RD_WAIT = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_din;
  logic [15:0] bus_addr;
  logic        bus_ale, bus_rd_n, bus_hi_weak, bus_wide, bus_ready_en;
  logic [1:0]  bus_timing;
  logic [7:0]  cfg0, cfg1;
  logic        boot_done, clk_out, phase1;

  always #5 clk = ~clk;

  rcfg_boot_seq #(.RD_WAIT(RD_WAIT)) dut (
    .clk(clk), .rst_n(rst_n), .bus_din(bus_din), .bus_addr(bus_addr),
    .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_hi_weak(bus_hi_weak),
    .bus_wide(bus_wide), .bus_ready_en(bus_ready_en), .bus_timing(bus_timing),
    .cfg0(cfg0), .cfg1(cfg1), .boot_done(boot_done),
    .clk_out(clk_out), .phase1(phase1)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // bus model and monitor
  logic [7:0]  m_ccb0, m_ccb1;
  logic [15:0] rec_addr [4];
  logic        rec_weak [4], rec_wide [4], rec_rdy [4], rec_boot [4];
  logic [1:0]  rec_tim  [4];
  int          rec_len  [4];
  int          n_ale, n_len, rd_cnt;

  always @(negedge clk) begin
    if (bus_ale && n_ale < 4) begin
      rec_addr[n_ale] = bus_addr;
      rec_weak[n_ale] = bus_hi_weak;
      rec_wide[n_ale] = bus_wide;
      rec_rdy[n_ale]  = bus_ready_en;
      rec_tim[n_ale]  = bus_timing;
      rec_boot[n_ale] = boot_done;
      n_ale++;
    end
    if (!bus_rd_n) rd_cnt++;
    else if (rd_cnt != 0) begin
      if (n_len < 4) rec_len[n_len] = rd_cnt;
      n_len++;
      rd_cnt = 0;
    end
    if (!bus_rd_n && rd_cnt == RD_WAIT) begin
      case (bus_addr)
        16'h2018: bus_din = {8'hEE, m_ccb0};
        16'h201A: bus_din = {8'hDD, m_ccb1};
        default:  bus_din = 16'h1234;
      endcase
    end else bus_din = 16'hA5C3;
  end

  task automatic clear_mon();
    n_ale = 0; n_len = 0; rd_cnt = 0;
  endtask

  task automatic t_reset_state();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(bus_ale == 1'b0,    "R1 ale",     bus_ale, 0);
    chk(bus_rd_n == 1'b1,   "R1 rd_n",    bus_rd_n, 1);
    chk(bus_addr == 16'h0,  "R1 addr",    bus_addr, 0);
    chk(bus_hi_weak == 1'b0,"R1 weak",    bus_hi_weak, 0);
    chk({bus_wide, bus_ready_en, bus_timing} == 4'h0, "R1 mode",
        {bus_wide, bus_ready_en, bus_timing}, 0);
    chk(cfg0 == 8'h0 && cfg1 == 8'h0, "R1 cfg", {cfg0, cfg1}, 0);
    chk(boot_done == 1'b0,  "R1 boot",    boot_done, 0);
    chk(clk_out == 1'b1,    "R1 clk_out", clk_out, 1);
  endtask

  task automatic t_boot(input logic [7:0] c0, input logic [7:0] c1);
    logic       exp_wide, exp_rdy;
    logic [1:0] exp_tim;
    int         guard;
    exp_wide = c0[1];
    exp_tim  = c0[3:2];
    exp_rdy  = c0[4];
    m_ccb0 = c0; m_ccb1 = c1;
    t_reset_state();
    clear_mon();
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(bus_ale == 1'b0, "R2 no strobe after 2 edges", bus_ale, 0);
    @(negedge clk);
    chk(bus_ale == 1'b1, "R2 strobe after 3 edges", bus_ale, 1);
    chk(clk_out == phase1, "R8 realigned", clk_out, phase1);
    guard = 0;
    while (n_len < 3 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
    chk(n_ale == 3, "R3 read count", n_ale, 3);
    chk(rec_addr[0] == 16'h2018, "R3 first addr",  rec_addr[0], 16'h2018);
    chk(rec_addr[1] == 16'h201A, "R3 second addr", rec_addr[1], 16'h201A);
    chk(rec_addr[2] == 16'h2080, "R3 fetch addr",  rec_addr[2], 16'h2080);
    for (int k = 0; k < 3; k++)
      chk(rec_len[k] == RD_WAIT, "R4 read strobe length", rec_len[k], RD_WAIT);
    chk(rec_wide[0] == 0 && rec_wide[1] == 0, "R5 narrow config reads",
        {rec_wide[0], rec_wide[1]}, 0);
    chk(cfg0 == c0, "R11 cfg0 (R5 R4 low byte, last cycle)", cfg0, c0);
    chk(cfg1 == c1, "R11 cfg1 (R5 R4 low byte, last cycle)", cfg1, c1);
    chk(rec_rdy[1] == 0 && rec_tim[1] == 0, "R6 default during second read",
        {rec_rdy[1], rec_tim[1]}, 0);
    chk(rec_wide[2] == exp_wide, "R6 width at fetch",  rec_wide[2], exp_wide);
    chk(rec_tim[2] == exp_tim,   "R6 timing at fetch", rec_tim[2], exp_tim);
    chk(rec_rdy[2] == exp_rdy,   "R6 ready at fetch",  rec_rdy[2], exp_rdy);
    chk(rec_weak[0] && rec_weak[1], "R7 weak in config reads",
        {rec_weak[0], rec_weak[1]}, 3);
    chk(!rec_weak[2] && !bus_hi_weak, "R7 strong at fetch and after",
        {rec_weak[2], bus_hi_weak}, 0);
    chk(!rec_boot[1] && rec_boot[2], "R9 boot at fetch strobe",
        {rec_boot[1], rec_boot[2]}, 1);
    chk(boot_done == 1'b1, "R9 boot held", boot_done, 1);
    for (int k = 0; k < 3; k++) begin
      logic prev;
      prev = clk_out;
      @(negedge clk);
      chk(clk_out == phase1 && clk_out != prev, "R8 clk_out follows phase1",
          {clk_out, phase1}, {~prev, ~prev});
    end
  endtask

  task automatic t_mid_reset();
    int guard;
    m_ccb0 = 8'h5A; m_ccb1 = 8'h33;
    t_reset_state();
    clear_mon();
    rst_n = 1'b1;
    guard = 0;
    while (!(n_ale == 2 && !bus_rd_n) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    chk(cfg0 == 8'h5A, "R10 first byte loaded before abort", cfg0, 8'h5A);
    rst_n = 1'b0;
    #1;
    chk(cfg0 == 8'h00, "R10 cfg0 cleared at once", cfg0, 0);
    chk(bus_rd_n == 1'b1 && bus_ale == 1'b0, "R10 strobes idle at once",
        {bus_ale, bus_rd_n}, 1);
    chk(bus_hi_weak == 1'b0 && boot_done == 1'b0, "R10 flags cleared",
        {bus_hi_weak, boot_done}, 0);
    t_boot(8'h04, 8'h81);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_din = 16'h0;
    m_ccb0 = 8'h0; m_ccb1 = 8'h0;
    clear_mon();
    t_boot(8'h1E, 8'hC7);
    t_boot(8'h04, 8'h6B);
    t_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule